// File: doc/BRIEF.md
# Two-Register Bidirectional Shifter

This block holds a 4-bit working value and moves it one bit position left or right. It has no multiplexed shift path. A small sequencer runs each shift as four clocked parallel transfers through a second, temporary register. First the working value is copied into the temporary register, which is always empty at that point. Next the working register is cleared. Then the temporary contents are copied back one position over, and finally the temporary register is emptied for the next request.

A start strobe accepted while idle launches a shift. The direction and the fill bit are captured together with the strobe. The fill bit enters the vacated end position, and the bit pushed off the far end appears on a shift-out output. The working register can be loaded in parallel, but only while the sequencer is idle. A busy flag covers the four phases, and a one-cycle done pulse follows the last phase.

Top module: `bidir_xfer_shifter`

## Requirements
- R1: After a synchronous active-low reset, data_o, shout_o, busy_o and done_o are all 0.
- R2: While idle, load_en_i high at a clock edge writes load_data_i into the working register, and the value appears on data_o after that edge.
- R3: start_i high at an edge while idle makes busy_o high for exactly four cycles, beginning right after that edge.
- R4: The temporary register is all zeros when the copy-up phase runs, and data_o reads all zeros during the third busy cycle, after the clear phase.
- R5: With dir_left_i = 1, the result is {old[2:0], fill} and shout_o is old[3]. Bit 3 is the most significant bit.
- R6: With dir_left_i = 0, the result is {fill, old[3:1]} and shout_o is old[0].
- R7: The direction and fill bit are sampled only at the accepted start edge. Changing them while busy has no effect on the result.
- R8: done_o is high for exactly one cycle, the first cycle after busy_o falls, and data_o then holds the shift result.
- R9: start_i asserted while busy is ignored. The running sequence neither restarts nor lengthens.
- R10: load_en_i asserted while busy is ignored. The working register changes only in the clear and copy-back phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request one shift (accepted only when idle) |
| dir_left_i | input | 1 | 1 = shift toward the MSB, 0 = toward the LSB |
| fill_i | input | 1 | Bit written into the vacated end position |
| load_en_i | input | 1 | Parallel load enable (idle only) |
| load_data_i | input | 4 | Parallel load value |
| data_o | output | 4 | Working register contents |
| shout_o | output | 1 | Bit pushed out by the most recent shift |
| busy_o | output | 1 | Sequencer is running its four phases |
| done_o | output | 1 | One-cycle pulse after the final phase |

## Verification
The assertions check the following on every cycle:
- the phase order;
- that the temporary register is empty at copy-up;
- that the working register is zero entering copy-back;
- that the working register stays still in the copy-up and temp-clear phases, whatever the load input does;
- the single-cycle done pulse;
- that a strobe while busy cannot disturb the sequence.

The shifted values, the fill and shift-out bits for each direction, and the capture of direction and fill at the start are shown only by the bench's scenarios. These scenarios compare each completed shift against an independent model.

// File: rtl/xfer_pkg.sv
// Package xfer_pkg
// Shared phase encoding for the two-register shifter.
// Assumes: one phase per clock cycle, visited in the listed order.
package xfer_pkg;
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_UP    = 3'd1,
        PH_CLRLO = 3'd2,
        PH_DOWN  = 3'd3,
        PH_CLRHI = 3'd4
    } phase_t;
endpackage

// File: rtl/xfer_sequencer.sv
// Module xfer_sequencer
// Steps through the four transfer phases after an accepted start.
// Captures the direction and fill bit at the start, and pulses done
// once after the last phase.
// Assumes: start is honoured only in PH_IDLE.
module xfer_sequencer
    import xfer_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_i,
    input  logic   dir_left_i,
    input  logic   fill_i,
    output phase_t phase_o,
    output logic   dir_left_o,
    output logic   fill_o,
    output logic   done_o
);
    phase_t phase_q;
    phase_t phase_d;

    // Next-phase selection.
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE:  if (start_i) phase_d = PH_UP;
            PH_UP:    phase_d = PH_CLRLO;
            PH_CLRLO: phase_d = PH_DOWN;
            PH_DOWN:  phase_d = PH_CLRHI;
            PH_CLRHI: phase_d = PH_IDLE;
            default:  phase_d = PH_IDLE;
        endcase
    end

    // Phase register, captured controls and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            dir_left_o <= 1'b0;
            fill_o     <= 1'b0;
            done_o     <= 1'b0;
        end else begin
            phase_q <= phase_d;
            done_o  <= (phase_q == PH_CLRHI);
            if (phase_q == PH_IDLE && start_i) begin
                dir_left_o <= dir_left_i;
                fill_o     <= fill_i;
            end
        end
    end

    assign phase_o = phase_q;

    p_order_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_UP) |=> (phase_q == PH_CLRLO));
    p_order_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_CLRLO) |=> (phase_q == PH_DOWN));
    p_order_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DOWN) |=> (phase_q == PH_CLRHI));
    p_done_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_CLRHI) |=> (done_o && phase_q == PH_IDLE));
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && phase_q == PH_CLRLO) |=> (phase_q == PH_DOWN));
    p_ctrl_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE) |=> ($stable(dir_left_o) && $stable(fill_o)));
endmodule

// File: rtl/xfer_temp_bank.sv
// Module xfer_temp_bank
// Upper, temporary register: takes the working value in copy-up and
// empties itself in the final phase.
// Assumes: it is empty whenever copy-up begins.
module xfer_temp_bank
    import xfer_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  phase_t       phase_i,
    input  logic [W-1:0] lo_i,
    output logic [W-1:0] hi_o
);
    // Copy-up and clear of the temporary bank.
    always_ff @(posedge clk) begin
        if (!rst_n)                     hi_o <= '0;
        else if (phase_i == PH_UP)      hi_o <= lo_i;
        else if (phase_i == PH_CLRHI)   hi_o <= '0;
    end

    p_temp_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == PH_UP) |-> (hi_o == '0));
endmodule

// File: rtl/xfer_work_bank.sv
// Module xfer_work_bank
// Lower, working register: parallel load while idle, clear in phase 2,
// offset copy-back from the temporary bank in phase 3.
// Assumes: the temporary bank holds the pre-shift value in phase 3.
module xfer_work_bank
    import xfer_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  phase_t       phase_i,
    input  logic         load_en_i,
    input  logic [W-1:0] load_data_i,
    input  logic [W-1:0] hi_i,
    input  logic         dir_left_i,
    input  logic         fill_i,
    output logic [W-1:0] lo_o,
    output logic         shout_o
);
    localparam int MSB = W - 1;

    logic [W-1:0] to_left;
    logic [W-1:0] to_right;

    // Build both one-position offset paths bit by bit.
    for (genvar i = 0; i < W; i++) begin : g_offset
        if (i == 0) begin : g_lsb
            assign to_left[i] = fill_i;
        end else begin : g_lmid
            assign to_left[i] = hi_i[i-1];
        end
        if (i == MSB) begin : g_msb
            assign to_right[i] = fill_i;
        end else begin : g_rmid
            assign to_right[i] = hi_i[i+1];
        end
    end

    // Working register and shift-out bit update per phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_o    <= '0;
            shout_o <= 1'b0;
        end else begin
            case (phase_i)
                PH_IDLE:  if (load_en_i) lo_o <= load_data_i;
                PH_CLRLO: lo_o <= '0;
                PH_DOWN: begin
                    lo_o    <= dir_left_i ? to_left : to_right;
                    shout_o <= dir_left_i ? hi_i[MSB] : hi_i[0];
                end
                default: ;
            endcase
        end
    end

    p_lo_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == PH_DOWN) |-> (lo_o == '0));
    p_load_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == PH_UP || phase_i == PH_CLRHI) |=> $stable(lo_o));
endmodule

// File: rtl/bidir_xfer_shifter.sv
// Module bidir_xfer_shifter
// Top level: one-position left/right shift done as four parallel
// transfers between a working bank and a temporary bank.
// Assumes: synchronous active-low reset; one request at a time.
module bidir_xfer_shifter
    import xfer_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         dir_left_i,
    input  logic         fill_i,
    input  logic         load_en_i,
    input  logic [W-1:0] load_data_i,
    output logic [W-1:0] data_o,
    output logic         shout_o,
    output logic         busy_o,
    output logic         done_o
);
    phase_t       phase;
    logic         dir_q;
    logic         fill_q;
    logic [W-1:0] hi;
    logic [W-1:0] lo;

    xfer_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .dir_left_i (dir_left_i),
        .fill_i     (fill_i),
        .phase_o    (phase),
        .dir_left_o (dir_q),
        .fill_o     (fill_q),
        .done_o     (done_o)
    );

    xfer_temp_bank #(.W(W)) u_hi (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_i (phase),
        .lo_i    (lo),
        .hi_o    (hi)
    );

    xfer_work_bank #(.W(W)) u_lo (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_i     (phase),
        .load_en_i   (load_en_i),
        .load_data_i (load_data_i),
        .hi_i        (hi),
        .dir_left_i  (dir_q),
        .fill_i      (fill_q),
        .lo_o        (lo),
        .shout_o     (shout_o)
    );

    // Busy covers the four transfer phases.
    assign busy_o = (phase != PH_IDLE);
    assign data_o = lo;
endmodule

// File: tb/tb_bidir_xfer_shifter.sv
module tb_bidir_xfer_shifter;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         dir_left_i = 1'b0;
    logic         fill_i = 1'b0;
    logic         load_en_i = 1'b0;
    logic [W-1:0] load_data_i = '0;
    logic [W-1:0] data_o;
    logic         shout_o;
    logic         busy_o;
    logic         done_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [W-1:0] model = '0;
    logic [W:0]   expq[$];

    bidir_xfer_shifter #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_left_i(dir_left_i),
        .fill_i(fill_i), .load_en_i(load_en_i), .load_data_i(load_data_i),
        .data_o(data_o), .shout_o(shout_o), .busy_o(busy_o), .done_o(done_o)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (expq.size() != 0) check(0, "R8 pending results", expq.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hang counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            check(0, "watchdog", cycles, 20000);
            finish_run();
        end
    end

    // Monitor: pop the expected result on each done pulse.
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (expq.size() == 0) begin
                check(0, "R8 unexpected done", 1, 0);
            end else begin
                logic [W:0] e;
                e = expq.pop_front();
                check(data_o == e[W-1:0], "R5/R6 data", data_o, e[W-1:0]);
                check(shout_o == e[W], "R5/R6 shout", shout_o, e[W]);
                check(busy_o == 1'b0, "R8 busy low at done", busy_o, 0);
            end
        end
    end

    task automatic load(input logic [W-1:0] v);
        load_en_i = 1'b1; load_data_i = v;
        @(negedge clk);
        load_en_i = 1'b0;
        model = v;
        check(data_o == v, "R2 load", data_o, v);
    endtask

    // Driver: one shift; optionally disturb inputs while busy (R7, R9, R10).
    task automatic run_shift(input logic dl, input logic fb, input bit disturb);
        logic [W-1:0] nv;
        logic         so;
        if (dl) begin nv = {model[W-2:0], fb}; so = model[W-1]; end
        else    begin nv = {fb, model[W-1:1]}; so = model[0];   end
        expq.push_back({so, nv});
        start_i = 1'b1; dir_left_i = dl; fill_i = fb;
        @(negedge clk);                      // after accept edge
        start_i = 1'b0;
        if (disturb) begin
            dir_left_i = ~dl; fill_i = ~fb; start_i = 1'b1;
            load_en_i = 1'b1; load_data_i = ~model;
        end
        check(busy_o == 1'b1, "R3 busy cycle 1", busy_o, 1);
        check(data_o == model, "R10 data held in copy-up", data_o, model);
        @(negedge clk);                      // after copy-up
        check(busy_o == 1'b1, "R3 busy cycle 2", busy_o, 1);
        @(negedge clk);                      // after clear-low
        check(data_o == '0, "R4 cleared", data_o, 0);
        check(busy_o == 1'b1, "R3 busy cycle 3", busy_o, 1);
        @(negedge clk);                      // after copy-down
        start_i = 1'b0; load_en_i = 1'b0;
        check(busy_o == 1'b1, "R3 busy cycle 4", busy_o, 1);
        check(data_o == nv, "R7 result before clear-high", data_o, nv);
        @(negedge clk);                      // after clear-high
        check(busy_o == 1'b0, "R3 busy ends", busy_o, 0);
        check(done_o == 1'b1, "R8 done", done_o, 1);
        @(negedge clk);
        check(done_o == 1'b0, "R8 done one cycle", done_o, 0);
        check(data_o == nv, "R9 no restart", data_o, nv);
        model = nv;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(data_o == '0, "R1 data", data_o, 0);
        check(shout_o == 1'b0, "R1 shout", shout_o, 0);
        check(busy_o == 1'b0, "R1 busy", busy_o, 0);
        check(done_o == 1'b0, "R1 done", done_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        load(4'b1011);
        run_shift(1'b1, 1'b0, 1'b0);         // R5 left, fill 0
        run_shift(1'b1, 1'b1, 1'b0);         // R5 left, fill 1
        load(4'b1101);
        run_shift(1'b0, 1'b0, 1'b0);         // R6 right, fill 0
        run_shift(1'b0, 1'b1, 1'b0);         // R6 right, fill 1
        load(4'b0110);
        run_shift(1'b1, 1'b1, 1'b1);         // R7 R9 R10 disturbed left
        run_shift(1'b0, 1'b0, 1'b1);         // R7 R9 R10 disturbed right
        load(4'b1000);
        run_shift(1'b1, 1'b0, 1'b0);         // R5 MSB shifted out
        load(4'b0001);
        run_shift(1'b0, 1'b0, 1'b0);         // R6 LSB shifted out
        for (int k = 0; k < 4; k++) run_shift(k[0], k[1], 1'b0);
        repeat (3) @(negedge clk);
        check(busy_o == 1'b0, "R9 stays idle", busy_o, 0);
        finish_run();
    end
endmodule